// File: doc/BRIEF.md
# Speculative value-prediction checker

This block decides whether a run of speculation built on a predicted load value may retire. When a load misses in the cache and is handed a guessed value, the pipeline opens a speculation window here. Every later load that consumes the guess is logged in a small table together with its address and the data it returned. When the true fill data comes back, the guess is compared with it. While the fill is outstanding, every coherence store or invalidation from another agent is checked against the logged addresses at cache-line granularity. The block ends each window with a one-cycle commit or squash.

A two-bit mode is captured when each window opens. Bit 0 turns on the address-snoop check, which is needed where the memory model orders loads linked by a data dependence. When it is clear, only the value comparison is used. Bit 1 turns on a value replay: after a matching fill, each logged load is re-read through a request/response port. Every value returned must equal the value the load used before. Each window is resolved before the next prediction is accepted.

Top module: `vp_spec_guard`

## Requirements
- R1: After reset, pred_ready_o is 1, and ld_ready_o, rpl_req_o, commit_o, squash_o and viol_o are all 0.
- R2: A prediction is taken only when pred_valid_i and pred_ready_o are both high. mode_i is latched in that cycle: bit 0 enables the snoop check and bit 1 enables replay. pred_ready_o stays 0 until the window resolves, and a pred_valid_i during an open window has no effect.
- R3: In the logging phase, a dependent load is logged when ld_valid_i and ld_ready_o are both high. ld_ready_o drops once 8 loads are held, and a ninth load offered then is not logged.
- R4: If fill_value_i differs from the predicted value, the window resolves as squash.
- R5: With snoop checking on, a snoop whose address bits above bit 5 equal those of any logged load sets viol_o in the next cycle. This includes a load logged in the same cycle as the snoop. viol_o holds until resolution, and resolution is then squash.
- R6: A matching-line snoop in the same cycle as the fill still turns that fill into a squash.
- R7: With snoop checking off, snoops never set viol_o, and a matching fill commits.
- R8: A snoop to a line held by no logged load has no effect.
- R9: With replay on and a matching fill, rpl_req_o is raised and rpl_addr_o steps through the logged loads in the order they were logged, one for each rpl_valid_i. Any rpl_value_i that differs from the logged value squashes. If all values match, the window commits. If no loads were logged, a matching fill commits at once.
- R10: Each window ends with exactly one of commit_o or squash_o, high for one cycle, in the cycle after the deciding fill or replay response. The table is then empty, so the next window again accepts 8 loads.
- R11: With both modes on, a matching snoop during the replay phase forces a squash even if all replayed values match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Bit 0 enables the snoop check, bit 1 enables replay; latched when a prediction is taken |
| pred_valid_i | input | 1 | Open a speculation window |
| pred_value_i | input | 32 | Predicted load value |
| pred_ready_o | output | 1 | No window is open |
| ld_valid_i | input | 1 | Dependent speculative load to log |
| ld_addr_i | input | 32 | Byte address of that load |
| ld_value_i | input | 32 | Value that load returned |
| ld_ready_o | output | 1 | Load can be logged |
| snp_valid_i | input | 1 | Remote store or invalidation |
| snp_addr_i | input | 32 | Snooped byte address |
| fill_valid_i | input | 1 | True data for the predicted load |
| fill_value_i | input | 32 | True value |
| rpl_req_o | output | 1 | Replay read requested |
| rpl_addr_o | output | 32 | Address to re-read |
| rpl_valid_i | input | 1 | Replay data returned |
| rpl_value_i | input | 32 | Re-read value |
| commit_o | output | 1 | Speculation may retire (one cycle) |
| squash_o | output | 1 | Speculation must be undone (one cycle) |
| viol_o | output | 1 | A possible ordering violation has been seen in this window |

## Verification
The hardest cases to reach are races at the window's edges. One is a snoop in the same cycle as the fill. Another is a snoop in the same cycle as the load it collides with. A third is a snoop that arrives while replay responses are held back. The stimulus lines these up on purpose, in single cycles and with gaps before replay responses. A behavioural model with queues checks every output on every clock. It also fills the table to capacity, then opens a new window, to show that resolution empties it.

// File: rtl/vp_guard_pkg.sv
package vp_guard_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned TAB_DEPTH  = 8;
  localparam int unsigned LINE_BYTES = 64;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SPEC   = 2'd1,
    PH_REPLAY = 2'd2
  } phase_e;

  typedef struct packed {
    logic replay_en;
    logic snoop_en;
  } mode_t;
endpackage

// File: rtl/vp_line_table.sv
module vp_line_table #(
  parameter int unsigned AW         = 32,
  parameter int unsigned DW         = 32,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned CNT_W     = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [DW-1:0]    wr_value_i,
  input  logic             snp_valid_i,
  input  logic [AW-1:0]    snp_addr_i,
  output logic             snp_hit_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [AW-1:0]    rd_addr_o,
  output logic [DW-1:0]    rd_value_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  localparam int unsigned OFS_W = $clog2(LINE_BYTES);

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    val_q  [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [DEPTH-1:0] hit_vec;
  logic             wr_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_q[g] <= '0;
        val_q[g]  <= '0;
      end else if (wr_i && (cnt_q == CNT_W'(g))) begin
        addr_q[g] <= wr_addr_i;
        val_q[g]  <= wr_value_i;
      end
    end
    assign hit_vec[g] = (CNT_W'(g) < cnt_q) &&
                        (addr_q[g][AW-1:OFS_W] == snp_addr_i[AW-1:OFS_W]);
  end

  // load written this cycle is also visible to a concurrent snoop
  assign wr_hit    = wr_i && (wr_addr_i[AW-1:OFS_W] == snp_addr_i[AW-1:OFS_W]);
  assign snp_hit_o = snp_valid_i && ((|hit_vec) || wr_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (wr_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign rd_addr_o  = addr_q[rd_idx_i];
  assign rd_value_o = val_q[rd_idx_i];
  assign cnt_o      = cnt_q;
  assign full_o     = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/vp_spec_ctrl.sv
module vp_spec_ctrl
  import vp_guard_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_i,
  input  logic             pred_valid_i,
  input  logic [DW-1:0]    pred_value_i,
  input  logic             ld_valid_i,
  input  logic             fill_valid_i,
  input  logic [DW-1:0]    fill_value_i,
  input  logic             snp_hit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             full_i,
  input  logic             rpl_valid_i,
  input  logic [DW-1:0]    rpl_value_i,
  input  logic [DW-1:0]    rd_value_i,
  output logic             pred_ready_o,
  output logic             ld_ready_o,
  output logic             ld_acc_o,
  output logic             clr_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             rpl_req_o,
  output logic             commit_o,
  output logic             squash_o,
  output logic             viol_o,
  output logic             snp_on_o,
  output logic [DW-1:0]    pred_o
);
  phase_e          phase_q, phase_d;
  mode_t           mode_q, mode_d;
  logic [DW-1:0]   pred_q, pred_d;
  logic            viol_q, viol_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic            commit_q, commit_d, squash_q, squash_d;
  logic            resolve, hit_now, last_ent;
  logic [CNT_W-1:0] cnt_after;

  assign pred_ready_o = (phase_q == PH_IDLE);
  assign ld_ready_o   = (phase_q == PH_SPEC) && !full_i;
  assign ld_acc_o     = ld_valid_i && ld_ready_o;
  assign snp_on_o     = mode_q.snoop_en && (phase_q != PH_IDLE);
  assign hit_now      = snp_hit_i && snp_on_o;
  assign cnt_after    = cnt_i + CNT_W'(ld_acc_o);
  assign last_ent     = ((CNT_W'(idx_q) + CNT_W'(1)) == cnt_i);

  always_comb begin
    phase_d  = phase_q;
    mode_d   = mode_q;
    pred_d   = pred_q;
    viol_d   = viol_q | hit_now;
    idx_d    = idx_q;
    commit_d = 1'b0;
    squash_d = 1'b0;
    resolve  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (pred_valid_i) begin
          phase_d = PH_SPEC;
          mode_d  = mode_t'(mode_i);
          pred_d  = pred_value_i;
          viol_d  = 1'b0;
        end
      end
      PH_SPEC: begin
        if (fill_valid_i) begin
          if (viol_q || hit_now || (fill_value_i != pred_q)) begin
            squash_d = 1'b1;
            resolve  = 1'b1;
          end else if (!mode_q.replay_en || (cnt_after == '0)) begin
            commit_d = 1'b1;
            resolve  = 1'b1;
          end else begin
            phase_d = PH_REPLAY;
            idx_d   = '0;
          end
        end
      end
      PH_REPLAY: begin
        if (rpl_valid_i) begin
          if (rpl_value_i != rd_value_i) begin
            squash_d = 1'b1;
            resolve  = 1'b1;
          end else if (last_ent) begin
            squash_d = viol_q || hit_now;
            commit_d = !(viol_q || hit_now);
            resolve  = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
    if (resolve) begin
      phase_d = PH_IDLE;
      viol_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      mode_q   <= '0;
      pred_q   <= '0;
      viol_q   <= 1'b0;
      idx_q    <= '0;
      commit_q <= 1'b0;
      squash_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      mode_q   <= mode_d;
      pred_q   <= pred_d;
      viol_q   <= viol_d;
      idx_q    <= idx_d;
      commit_q <= commit_d;
      squash_q <= squash_d;
    end
  end

  assign clr_o     = resolve;
  assign rd_idx_o  = idx_q;
  assign rpl_req_o = (phase_q == PH_REPLAY);
  assign commit_o  = commit_q;
  assign squash_o  = squash_q;
  assign viol_o    = viol_q;
  assign pred_o    = pred_q;
endmodule

// File: rtl/vp_spec_guard.sv
module vp_spec_guard
  import vp_guard_pkg::*;
#(
  parameter int unsigned AW         = ADDR_W,
  parameter int unsigned DW         = DATA_W,
  parameter int unsigned DEPTH      = TAB_DEPTH,
  parameter int unsigned LINE_SIZE  = LINE_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          pred_valid_i,
  input  logic [DW-1:0] pred_value_i,
  output logic          pred_ready_o,
  input  logic          ld_valid_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_value_i,
  output logic          ld_ready_o,
  input  logic          snp_valid_i,
  input  logic [AW-1:0] snp_addr_i,
  input  logic          fill_valid_i,
  input  logic [DW-1:0] fill_value_i,
  output logic          rpl_req_o,
  output logic [AW-1:0] rpl_addr_o,
  input  logic          rpl_valid_i,
  input  logic [DW-1:0] rpl_value_i,
  output logic          commit_o,
  output logic          squash_o,
  output logic          viol_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             ld_acc, tab_clr, snp_hit, tab_full, snp_on;
  logic [CNT_W-1:0] tab_cnt;
  logic [IDX_W-1:0] rd_idx;
  logic [DW-1:0]    rd_value, pred_val;

  vp_line_table #(
    .AW(AW), .DW(DW), .DEPTH(DEPTH), .LINE_BYTES(LINE_SIZE)
  ) i_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (tab_clr),
    .wr_i       (ld_acc),
    .wr_addr_i  (ld_addr_i),
    .wr_value_i (ld_value_i),
    .snp_valid_i(snp_valid_i),
    .snp_addr_i (snp_addr_i),
    .snp_hit_o  (snp_hit),
    .rd_idx_i   (rd_idx),
    .rd_addr_o  (rpl_addr_o),
    .rd_value_o (rd_value),
    .cnt_o      (tab_cnt),
    .full_o     (tab_full)
  );

  vp_spec_ctrl #(
    .DW(DW), .DEPTH(DEPTH)
  ) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .pred_valid_i(pred_valid_i),
    .pred_value_i(pred_value_i),
    .ld_valid_i  (ld_valid_i),
    .fill_valid_i(fill_valid_i),
    .fill_value_i(fill_value_i),
    .snp_hit_i   (snp_hit),
    .cnt_i       (tab_cnt),
    .full_i      (tab_full),
    .rpl_valid_i (rpl_valid_i),
    .rpl_value_i (rpl_value_i),
    .rd_value_i  (rd_value),
    .pred_ready_o(pred_ready_o),
    .ld_ready_o  (ld_ready_o),
    .ld_acc_o    (ld_acc),
    .clr_o       (tab_clr),
    .rd_idx_o    (rd_idx),
    .rpl_req_o   (rpl_req_o),
    .commit_o    (commit_o),
    .squash_o    (squash_o),
    .viol_o      (viol_o),
    .snp_on_o    (snp_on),
    .pred_o      (pred_val)
  );
endmodule

// File: rtl/vp_guard_chk.sv
module vp_guard_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             commit_o,
  input logic             squash_o,
  input logic             viol_o,
  input logic             pred_ready_o,
  input logic             ld_ready_o,
  input logic             rpl_req_o,
  input logic             fill_valid_i,
  input logic [DW-1:0]    fill_value_i,
  input logic [DW-1:0]    pred_val,
  input logic             snp_on,
  input logic [CNT_W-1:0] tab_cnt
);
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && squash_o)); // R10
  AST_COMMIT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o); // R10
  AST_SQUASH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |=> !squash_o); // R10
  AST_IDLE_AFTER_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || squash_o) |-> pred_ready_o); // R2
  AST_REPLAY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpl_req_o |-> !pred_ready_o); // R2
  AST_TABLE_FULL_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tab_cnt == CNT_W'(DEPTH)) |-> !ld_ready_o); // R3
  AST_MISMATCH_SQUASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !pred_ready_o && !rpl_req_o && (fill_value_i != pred_val))
      |=> squash_o); // R4
  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> (viol_o || squash_o)); // R5
  AST_VIOL_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |=> !commit_o); // R5
  AST_SNOOP_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snp_on |-> !viol_o); // R7
endmodule

bind vp_spec_guard vp_guard_chk #(.DW(DW), .DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .commit_o    (commit_o),
  .squash_o    (squash_o),
  .viol_o      (viol_o),
  .pred_ready_o(pred_ready_o),
  .ld_ready_o  (ld_ready_o),
  .rpl_req_o   (rpl_req_o),
  .fill_valid_i(fill_valid_i),
  .fill_value_i(fill_value_i),
  .pred_val    (pred_val),
  .snp_on      (snp_on),
  .tab_cnt     (tab_cnt)
);

// File: tb/test_vp_spec_guard.sv
`timescale 1ns/1ps
module test_vp_spec_guard;
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = '0;
  logic        pred_valid_i = 1'b0;
  logic [31:0] pred_value_i = '0;
  logic        ld_valid_i = 1'b0;
  logic [31:0] ld_addr_i = '0;
  logic [31:0] ld_value_i = '0;
  logic        snp_valid_i = 1'b0;
  logic [31:0] snp_addr_i = '0;
  logic        fill_valid_i = 1'b0;
  logic [31:0] fill_value_i = '0;
  logic        rpl_valid_i = 1'b0;
  logic [31:0] rpl_value_i = '0;
  logic        pred_ready_o, ld_ready_o, rpl_req_o, commit_o, squash_o, viol_o;
  logic [31:0] rpl_addr_o;

  vp_spec_guard i_vp_spec_guard (
    .clk_i, .rst_ni, .mode_i, .pred_valid_i, .pred_value_i, .pred_ready_o,
    .ld_valid_i, .ld_addr_i, .ld_value_i, .ld_ready_o, .snp_valid_i, .snp_addr_i,
    .fill_valid_i, .fill_value_i, .rpl_req_o, .rpl_addr_o, .rpl_valid_i, .rpl_value_i,
    .commit_o, .squash_o, .viol_o
  );

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0;
  int n_err = 0;
  int out_seen = 0;  // 0 none, 1 commit, 2 squash

  // reference model
  int          m_state = 0;  // 0 idle, 1 logging, 2 replay
  bit          m_snp = 0, m_rpl = 0, m_viol = 0, m_commit = 0, m_squash = 0;
  logic [31:0] m_pred = '0;
  int          m_idx = 0;
  logic [31:0] m_qa[$];
  logic [31:0] m_qv[$];

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit same_line(logic [31:0] a, logic [31:0] b);
    return a[31:6] == b[31:6];
  endfunction

  task automatic cyc();
    int n_state = m_state;
    bit n_snp = m_snp, n_rpl = m_rpl, n_viol, n_commit = 0, n_squash = 0;
    logic [31:0] n_pred = m_pred;
    int n_idx = m_idx;
    bit hit = 0, res = 0;
    if (m_state == 1 && ld_valid_i && m_qa.size() < DEPTH) begin
      m_qa.push_back(ld_addr_i);
      m_qv.push_back(ld_value_i);
    end
    if (m_state != 0 && m_snp && snp_valid_i)
      foreach (m_qa[k]) if (same_line(m_qa[k], snp_addr_i)) hit = 1;
    n_viol = m_viol | hit;
    case (m_state)
      0: if (pred_valid_i) begin
        n_state = 1; n_snp = mode_i[0]; n_rpl = mode_i[1]; n_pred = pred_value_i; n_viol = 0;
      end
      1: if (fill_valid_i) begin
        if (m_viol || hit || fill_value_i != m_pred) begin n_squash = 1; res = 1; end
        else if (!m_rpl || m_qa.size() == 0) begin n_commit = 1; res = 1; end
        else begin n_state = 2; n_idx = 0; end
      end
      2: if (rpl_valid_i) begin
        if (rpl_value_i != m_qv[m_idx]) begin n_squash = 1; res = 1; end
        else if (m_idx == m_qa.size() - 1) begin
          if (m_viol || hit) n_squash = 1; else n_commit = 1;
          res = 1;
        end else n_idx = m_idx + 1;
      end
      default: ;
    endcase
    if (res) begin n_state = 0; n_viol = 0; end
    @(posedge clk_i); #1;
    m_state = n_state; m_snp = n_snp; m_rpl = n_rpl; m_pred = n_pred; m_viol = n_viol;
    m_idx = n_idx; m_commit = n_commit; m_squash = n_squash;
    if (res) begin m_qa.delete(); m_qv.delete(); end
    chk("R2", "pred_ready_o", pred_ready_o, m_state == 0);
    chk("R3", "ld_ready_o", ld_ready_o, (m_state == 1) && (m_qa.size() < DEPTH));
    chk("R9", "rpl_req_o", rpl_req_o, m_state == 2);
    if (m_state == 2) chk("R9", "rpl_addr_o", rpl_addr_o, m_qa[m_idx]);
    chk("R10", "commit_o", commit_o, m_commit);
    chk("R10", "squash_o", squash_o, m_squash);
    chk("R5", "viol_o", viol_o, m_viol);
    if (commit_o) out_seen = 1;
    if (squash_o) out_seen = 2;
    pred_valid_i = 0; ld_valid_i = 0; snp_valid_i = 0; fill_valid_i = 0; rpl_valid_i = 0;
  endtask

  task automatic open_win(logic [1:0] m, logic [31:0] v);
    mode_i = m; pred_valid_i = 1; pred_value_i = v; out_seen = 0; cyc();
  endtask
  task automatic log_ld(logic [31:0] a, logic [31:0] v);
    ld_valid_i = 1; ld_addr_i = a; ld_value_i = v; cyc();
  endtask
  task automatic snoop(logic [31:0] a);
    snp_valid_i = 1; snp_addr_i = a; cyc();
  endtask
  task automatic fill(logic [31:0] v);
    fill_valid_i = 1; fill_value_i = v; cyc();
  endtask
  task automatic replay(int bad, int gap, bit snp_mid, logic [31:0] snp_a);
    int guard = 0;
    while (rpl_req_o && guard < 40) begin
      for (int g = 0; g < gap; g++) begin
        if (snp_mid && g == 0) begin snp_valid_i = 1; snp_addr_i = snp_a; end
        cyc();
      end
      rpl_valid_i = 1;
      rpl_value_i = (m_idx == bad) ? (m_qv[m_idx] ^ 32'h1) : m_qv[m_idx];
      cyc();
      guard++;
    end
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1", "pred_ready_o", pred_ready_o, 1);
    chk("R1", "ld_ready_o", ld_ready_o, 0);
    chk("R1", "outputs", {rpl_req_o, commit_o, squash_o, viol_o}, 0);
    rst_ni = 1;
    cyc();
    snoop(32'h0000_1000);  // idle snoop ignored
    chk("R1", "viol_o idle", viol_o, 0);

    // value only, matching fill commits
    open_win(2'b00, 32'h55);
    log_ld(32'h1000, 32'h11); log_ld(32'h1008, 32'h12); log_ld(32'h2000, 32'h13);
    fill(32'h55); cyc();
    chk("R10", "commit basic", out_seen, 1);

    // R4 mismatch
    open_win(2'b00, 32'h77);
    log_ld(32'h3000, 32'h1);
    fill(32'h78); cyc();
    chk("R4", "mismatch outcome", out_seen, 2);

    // R2 pred during open window ignored, R7 snoop off
    open_win(2'b00, 32'hA0);
    log_ld(32'h4000, 32'h2);
    mode_i = 2'b01; pred_valid_i = 1; pred_value_i = 32'hB0; cyc();
    snoop(32'h4010);
    chk("R7", "viol_o snoop off", viol_o, 0);
    fill(32'hA0); cyc();
    chk("R2", "outcome busy pred", out_seen, 1);

    // R5 matching line snoop
    open_win(2'b01, 32'h5);
    log_ld(32'h2000, 32'h3); log_ld(32'h5000, 32'h4);
    snoop(32'h203C);
    chk("R5", "viol set", viol_o, 1);
    cyc(); cyc();
    chk("R5", "viol held", viol_o, 1);
    fill(32'h5); cyc();
    chk("R5", "outcome", out_seen, 2);

    // R5 snoop together with the load it hits
    open_win(2'b01, 32'h6);
    ld_valid_i = 1; ld_addr_i = 32'h6000; ld_value_i = 32'h9;
    snp_valid_i = 1; snp_addr_i = 32'h6020; cyc();
    chk("R5", "viol same-cycle load", viol_o, 1);
    fill(32'h6); cyc();
    chk("R5", "outcome same-cycle load", out_seen, 2);

    // R8 other lines
    open_win(2'b01, 32'h7);
    log_ld(32'h1000, 32'h5);
    snoop(32'h1040); snoop(32'h0FC0);
    chk("R8", "viol other line", viol_o, 0);
    fill(32'h7); cyc();
    chk("R8", "outcome", out_seen, 1);

    // R6 snoop in fill cycle
    open_win(2'b01, 32'h8);
    log_ld(32'h7000, 32'h6);
    snp_valid_i = 1; snp_addr_i = 32'h7004; fill_valid_i = 1; fill_value_i = 32'h8; cyc();
    cyc();
    chk("R6", "outcome", out_seen, 2);

    // R3 table capacity
    open_win(2'b01, 32'h9);
    for (int i = 0; i < 9; i++) log_ld(32'h8000 + 32'(i) * 32'h40, 32'(i));
    chk("R3", "ld_ready_o full", ld_ready_o, 0);
    snoop(32'h8000 + 32'h1C0 + 32'h8);
    chk("R3", "last entry tracked", viol_o, 1);
    snoop(32'h8200);  // would-be ninth load, never logged
    fill(32'h9); cyc();
    chk("R3", "outcome", out_seen, 2);

    // R10 table cleared by resolution
    open_win(2'b00, 32'hA);
    for (int i = 0; i < 7; i++) log_ld(32'h9000 + 32'(i) * 4, 32'(i));
    chk("R10", "ld_ready after clear", ld_ready_o, 1);
    log_ld(32'h9100, 32'h77);
    chk("R10", "ld_ready at 8", ld_ready_o, 0);
    fill(32'hA); cyc();

    // R9 replay, all match, with gaps
    open_win(2'b10, 32'hB);
    log_ld(32'hA000, 32'h21); log_ld(32'hA100, 32'h22); log_ld(32'hA200, 32'h23);
    fill(32'hB);
    chk("R9", "replay started", rpl_req_o, 1);
    chk("R9", "first addr", rpl_addr_o, 32'hA000);
    replay(-1, 2, 0, 0);
    chk("R9", "replay commit", out_seen, 1);

    // R9 replay mismatch on second entry
    open_win(2'b10, 32'hC);
    log_ld(32'hB000, 32'h31); log_ld(32'hB040, 32'h32); log_ld(32'hB080, 32'h33);
    fill(32'hC);
    replay(1, 0, 0, 0);
    chk("R9", "replay squash", out_seen, 2);

    // R9 no loads logged
    open_win(2'b10, 32'hD);
    fill(32'hD); cyc();
    chk("R9", "empty replay commit", out_seen, 1);

    // R11 snoop during replay
    open_win(2'b11, 32'hE);
    log_ld(32'hC000, 32'h41); log_ld(32'hC100, 32'h42);
    fill(32'hE);
    replay(-1, 1, 1, 32'hC120);
    chk("R11", "outcome", out_seen, 2);

    // R7 snoop off with replay: commit
    open_win(2'b10, 32'hF);
    log_ld(32'hD000, 32'h51);
    snoop(32'hD000);
    fill(32'hF);
    replay(-1, 0, 0, 0);
    chk("R7", "outcome replay only", out_seen, 1);

    repeat (3) cyc();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule